// File: doc/BRIEF.md
# Nonvolatile Memory Access Protection Controller

This block guards a small on-chip nonvolatile array that two requesters share. One requester is an external programming port. The other is an internal port, which the CPU uses for self-writes and table reads. Every request address is decoded into one of seven regions:

- boot block
- application block
- storage-area block
- data EEPROM
- configuration bytes
- user ID
- factory information

Two configuration words in the array hold active-low protection bits. The block checks those bits against the requester and the region. It then performs the access, returns zeros in place of the data, or drops the access.

When an internal self-write is blocked, a sticky error flag is raised. An external bulk-erase pulse starts a multi-cycle sequence. The sequence writes all ones to every word below the factory region, and clearing the protection words lifts every protection. The factory words are not touched.

Both request ports use valid/ready. A request is taken on a clock edge where valid and ready are both high. The requester must hold valid, address, write enable and data stable until that edge.

A read answers exactly one cycle after acceptance, as a one-cycle rvalid pulse with data. The response cannot be back-pressured.

Ready is the only back-pressure. It is withdrawn during an erase and in the cycle an erase is requested. On the internal port it is also withdrawn whenever the external port has valid high.

Top module: `nvm_guard`

## Requirements
- R1: With default parameters, addresses decode as follows: 0x00-0x1F boot, 0x20-0x9F application, 0xA0-0xBF storage area, 0xC0-0xDF data EEPROM, 0xE0-0xE7 configuration, 0xE8-0xEF user ID, 0xF0-0xFF factory. After reset, every word reads 0xFF except a factory word at address a, which reads (a*37+11) mod 256.
- R2: ext_ready is high exactly when busy is low and ext_erase is low. int_ready is high exactly when busy, ext_erase and ext_valid are all low, so the external port wins a same-cycle contest.
- R3: An accepted read gives a one-cycle rvalid pulse on its own port, with data, in the following cycle. A write produces no rvalid.
- R4: When bit 0 of word 0xE0 (program code-protect, active low) is 0, external reads of boot, application and storage-area words return 0x00, and external writes to those words are dropped.
- R5: When bit 1 of word 0xE0 (data code-protect, active low) is 0, external reads of data EEPROM return 0x00 and external writes to it are dropped. This bit acts independently of bit 0.
- R6: Code-protect bits have no effect on internal reads or internal writes.
- R7: Bits 0 to 4 of word 0xE1 are the active-low write-protect bits for boot, application, storage area, data EEPROM and configuration, in that order. A 0 drops external and internal writes to that region. Internal reads are still served.
- R8: An accepted internal write dropped by a write-protect bit sets wr_err. wr_err stays set until int_err_clr is high at a clock edge with no new blocked internal write; a set wins over a clear in the same cycle. Dropped external writes never set wr_err.
- R9: User ID words can be read and written from both ports regardless of any protection bit. Factory words are read-only: writes from either port are dropped without setting wr_err.
- R10: ext_erase, seen while busy is low, raises busy for 242 cycles (FACT_BASE+2). During that time neither port accepts a request. Afterwards every word below 0xF0 reads 0xFF, so all protection is lifted. Factory words and wr_err keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_valid | input | 1 | External request valid |
| ext_ready | output | 1 | External request accepted this cycle |
| ext_we | input | 1 | External request is a write |
| ext_addr | input | AW | External word address |
| ext_wdata | input | DW | External write data |
| ext_rvalid | output | 1 | External read response valid |
| ext_rdata | output | DW | External read data (zero when masked) |
| ext_erase | input | 1 | Bulk-erase request pulse |
| int_valid | input | 1 | Internal request valid |
| int_ready | output | 1 | Internal request accepted this cycle |
| int_we | input | 1 | Internal request is a self-write |
| int_addr | input | AW | Internal word address |
| int_wdata | input | DW | Internal write data |
| int_rvalid | output | 1 | Internal read response valid |
| int_rdata | output | DW | Internal read data |
| int_err_clr | input | 1 | Clears the sticky write-error flag |
| wr_err | output | 1 | Sticky blocked self-write flag |
| busy | output | 1 | Bulk erase in progress |

## Verification
Three pairs of functions can land on the same clock edge:

- Both ports can present a request in one cycle. The bench raises both valids together and holds the internal one. The check is that the external access lands first, and that the internal access is taken exactly one edge later.
- A blocked self-write can arrive in the same cycle as int_err_clr. The expected flag is set.
- An erase request can meet a pending external request. The expected result is that the request is refused for the whole busy window.

A behavioural reference model in the bench judges every cycle, covering ready, rvalid, rdata, busy and wr_err.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [2:0] {
    RG_BOOT = 3'd0,
    RG_APP  = 3'd1,
    RG_SAF  = 3'd2,
    RG_EEP  = 3'd3,
    RG_CFG  = 3'd4,
    RG_UID  = 3'd5,
    RG_FACT = 3'd6
  } region_e;

  localparam int NUM_BOUND = 6;
  localparam int NUM_WP    = 5;

  typedef struct packed {
    logic              pgm_cp_n;
    logic              dat_cp_n;
    logic [NUM_WP-1:0] wp_n;
  } prot_t;

  // Factory signature stored at reset in read-only words.
  function automatic int fact_sig(input int a);
    return a * 37 + 11;
  endfunction

endpackage

// File: rtl/nvm_region_dec.sv
module nvm_region_dec
  import nvm_guard_pkg::*;
#(
  parameter int AW        = 8,
  parameter int APP_BASE  = 32,
  parameter int SAF_BASE  = 160,
  parameter int EEP_BASE  = 192,
  parameter int CFG_BASE  = 224,
  parameter int UID_BASE  = 232,
  parameter int FACT_BASE = 240
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);

  localparam int BOUND [NUM_BOUND] = '{APP_BASE, SAF_BASE, EEP_BASE,
                                       CFG_BASE, UID_BASE, FACT_BASE};

  logic [NUM_BOUND-1:0] above;

  genvar g;
  generate
    for (g = 0; g < NUM_BOUND; g++) begin : g_cmp
      assign above[g] = ({1'b0, addr} >= (AW+1)'(BOUND[g]));
    end
  endgenerate

  // Regions are ordered, so the count of passed bounds is the region index.
  always_comb begin
    region = RG_BOOT;
    for (int i = 0; i < NUM_BOUND; i++) begin
      if (above[i]) region = region_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/nvm_access_policy.sv
module nvm_access_policy
  import nvm_guard_pkg::*;
(
  input  region_e region,
  input  logic    from_ext,
  input  logic    is_wr,
  input  prot_t   prot,
  output logic    allow,
  output logic    zero_rd,
  output logic    flag_err
);

  logic is_pgm;
  logic cp_hit;
  logic wp_hit;
  logic ro_hit;

  assign is_pgm = (region == RG_BOOT) || (region == RG_APP) || (region == RG_SAF);
  assign cp_hit = (is_pgm && !prot.pgm_cp_n) || ((region == RG_EEP) && !prot.dat_cp_n);
  assign ro_hit = (region == RG_FACT);

  always_comb begin
    case (region)
      RG_BOOT: wp_hit = !prot.wp_n[0];
      RG_APP:  wp_hit = !prot.wp_n[1];
      RG_SAF:  wp_hit = !prot.wp_n[2];
      RG_EEP:  wp_hit = !prot.wp_n[3];
      RG_CFG:  wp_hit = !prot.wp_n[4];
      default: wp_hit = 1'b0;
    endcase
  end

  always_comb begin
    allow    = 1'b1;
    zero_rd  = 1'b0;
    flag_err = 1'b0;
    if (is_wr) begin
      allow    = !(wp_hit || ro_hit || (from_ext && cp_hit));
      flag_err = !from_ext && wp_hit;
    end else begin
      zero_rd = from_ext && cp_hit;
    end
  end

endmodule

// File: rtl/nvm_erase_seq.sv
module nvm_erase_seq #(
  parameter int AW          = 8,
  parameter int ERASE_WORDS = 240,
  parameter int PROT_A0     = 224,
  parameter int PROT_A1     = 225
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic          cfg_clr
);

  typedef enum logic [1:0] {ES_IDLE, ES_ERASE, ES_CLRCFG, ES_DONE} es_e;

  es_e           state_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ES_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ES_IDLE: if (start) begin
          state_q <= ES_ERASE;
          addr_q  <= '0;
        end
        ES_ERASE: begin
          if (addr_q == AW'(ERASE_WORDS - 1)) state_q <= ES_CLRCFG;
          else addr_q <= addr_q + 1'b1;
        end
        ES_CLRCFG: state_q <= ES_DONE;
        default:   state_q <= ES_IDLE;
      endcase
    end
  end

  // Protection words are left for last so protection holds while data is wiped.
  assign busy    = (state_q != ES_IDLE);
  assign addr    = addr_q;
  assign we      = (state_q == ES_ERASE) && (addr_q != AW'(PROT_A0)) && (addr_q != AW'(PROT_A1));
  assign cfg_clr = (state_q == ES_CLRCFG);

endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_guard_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int FACT_BASE = 240,
  parameter int PROT_A0   = 224,
  parameter int PROT_A1   = 225
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata,
  input  logic              cfg_clr,
  output logic [1:0]        cp_bits,
  output logic [NUM_WP-1:0] wp_bits
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i >= FACT_BASE) ? DW'(fact_sig(i)) : {DW{1'b1}};
      end
      rdata <= '0;
    end else begin
      if (cfg_clr) begin
        mem[PROT_A0] <= {DW{1'b1}};
        mem[PROT_A1] <= {DW{1'b1}};
      end else if (we) begin
        mem[waddr] <= wdata;
      end
      if (re) rdata <= mem[raddr];
    end
  end

  assign cp_bits = mem[PROT_A0][1:0];
  assign wp_bits = mem[PROT_A1][NUM_WP-1:0];

endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_guard_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int APP_BASE  = 32,
  parameter int SAF_BASE  = 160,
  parameter int EEP_BASE  = 192,
  parameter int CFG_BASE  = 224,
  parameter int UID_BASE  = 232,
  parameter int FACT_BASE = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_rvalid,
  output logic [DW-1:0] ext_rdata,
  input  logic          ext_erase,
  input  logic          int_valid,
  output logic          int_ready,
  input  logic          int_we,
  input  logic [AW-1:0] int_addr,
  input  logic [DW-1:0] int_wdata,
  output logic          int_rvalid,
  output logic [DW-1:0] int_rdata,
  input  logic          int_err_clr,
  output logic          wr_err,
  output logic          busy
);

  localparam int PROT_A0 = CFG_BASE;
  localparam int PROT_A1 = CFG_BASE + 1;

  logic              ext_fire, int_fire, acc_fire, acc_we;
  logic [AW-1:0]     acc_addr;
  logic [DW-1:0]     acc_wdata;
  region_e           region;
  prot_t             prot;
  logic [1:0]        cp_bits;
  logic [NUM_WP-1:0] wp_bits;
  logic              allow, zero_rd, flag_err;
  logic              er_we, er_cfg_clr;
  logic [AW-1:0]     er_addr;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DW-1:0]     mem_wdata, mem_rdata;
  logic              ext_rv_q, int_rv_q, ext_zero_q, err_q;

  assign ext_ready = !busy && !ext_erase;
  assign int_ready = !busy && !ext_erase && !ext_valid;
  assign ext_fire  = ext_valid && ext_ready;
  assign int_fire  = int_valid && int_ready;
  assign acc_fire  = ext_fire || int_fire;
  assign acc_we    = ext_fire ? ext_we    : int_we;
  assign acc_addr  = ext_fire ? ext_addr  : int_addr;
  assign acc_wdata = ext_fire ? ext_wdata : int_wdata;

  assign prot.pgm_cp_n = cp_bits[0];
  assign prot.dat_cp_n = cp_bits[1];
  assign prot.wp_n     = wp_bits;

  nvm_region_dec #(
    .AW(AW), .APP_BASE(APP_BASE), .SAF_BASE(SAF_BASE), .EEP_BASE(EEP_BASE),
    .CFG_BASE(CFG_BASE), .UID_BASE(UID_BASE), .FACT_BASE(FACT_BASE)
  ) u_dec (
    .addr   (acc_addr),
    .region (region)
  );

  nvm_access_policy u_pol (
    .region   (region),
    .from_ext (ext_fire),
    .is_wr    (acc_we),
    .prot     (prot),
    .allow    (allow),
    .zero_rd  (zero_rd),
    .flag_err (flag_err)
  );

  nvm_erase_seq #(
    .AW(AW), .ERASE_WORDS(FACT_BASE), .PROT_A0(PROT_A0), .PROT_A1(PROT_A1)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ext_erase && !busy),
    .busy    (busy),
    .we      (er_we),
    .addr    (er_addr),
    .cfg_clr (er_cfg_clr)
  );

  assign mem_we    = er_we || (acc_fire && acc_we && allow);
  assign mem_waddr = er_we ? er_addr : acc_addr;
  assign mem_wdata = er_we ? {DW{1'b1}} : acc_wdata;

  nvm_store #(
    .AW(AW), .DW(DW), .FACT_BASE(FACT_BASE), .PROT_A0(PROT_A0), .PROT_A1(PROT_A1)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .re      (acc_fire && !acc_we),
    .raddr   (acc_addr),
    .rdata   (mem_rdata),
    .cfg_clr (er_cfg_clr),
    .cp_bits (cp_bits),
    .wp_bits (wp_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_rv_q   <= 1'b0;
      int_rv_q   <= 1'b0;
      ext_zero_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      ext_rv_q   <= ext_fire && !ext_we;
      int_rv_q   <= int_fire && !int_we;
      ext_zero_q <= ext_fire && zero_rd;
      if (int_fire && int_we && flag_err) err_q <= 1'b1;
      else if (int_err_clr)               err_q <= 1'b0;
    end
  end

  assign ext_rvalid = ext_rv_q;
  assign ext_rdata  = ext_zero_q ? '0 : mem_rdata;
  assign int_rvalid = int_rv_q;
  assign int_rdata  = mem_rdata;
  assign wr_err     = err_q;

endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk #(
  parameter int NWP = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ext_valid,
  input logic           ext_ready,
  input logic           ext_we,
  input logic           ext_rvalid,
  input logic           ext_erase,
  input logic           int_valid,
  input logic           int_ready,
  input logic           int_we,
  input logic           int_rvalid,
  input logic           int_err_clr,
  input logic           wr_err,
  input logic           busy,
  input logic [1:0]     cp_bits,
  input logic [NWP-1:0] wp_bits
);

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ext_ready && !int_ready));

  // R2
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> !int_ready);

  // R3
  ext_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && ext_ready && !ext_we) |=> ext_rvalid);

  // R3
  int_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_ready && !int_we) |=> int_rvalid);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !int_err_clr) |=> wr_err);

  // R10
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_erase && !busy) |=> busy);

  // R10
  erase_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((&cp_bits) && (&wp_bits)));

endmodule

bind nvm_guard nvm_guard_chk #(.NWP(5)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_valid   (ext_valid),
  .ext_ready   (ext_ready),
  .ext_we      (ext_we),
  .ext_rvalid  (ext_rvalid),
  .ext_erase   (ext_erase),
  .int_valid   (int_valid),
  .int_ready   (int_ready),
  .int_we      (int_we),
  .int_rvalid  (int_rvalid),
  .int_err_clr (int_err_clr),
  .wr_err      (wr_err),
  .busy        (busy),
  .cp_bits     (cp_bits),
  .wp_bits     (wp_bits)
);

// File: tb/nvm_guard_bench.sv
module nvm_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_valid = 1'b0, ext_we = 1'b0, ext_erase = 1'b0;
  logic [7:0] ext_addr = '0, ext_wdata = '0;
  logic       int_valid = 1'b0, int_we = 1'b0, int_err_clr = 1'b0;
  logic [7:0] int_addr = '0, int_wdata = '0;
  logic       ext_ready, ext_rvalid, int_ready, int_rvalid, wr_err, busy;
  logic [7:0] ext_rdata, int_rdata;

  always #10 clk = ~clk;

  nvm_guard u_nvm_guard (
    .clk(clk), .rst_n(rst_n),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rvalid(ext_rvalid),
    .ext_rdata(ext_rdata), .ext_erase(ext_erase),
    .int_valid(int_valid), .int_ready(int_ready), .int_we(int_we),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_rvalid(int_rvalid),
    .int_rdata(int_rdata), .int_err_clr(int_err_clr),
    .wr_err(wr_err), .busy(busy)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Reference model state
  int m_mem [256];
  int m_left, m_err, x_erv, x_erd, x_irv, x_ird;

  function automatic int rgn(input int a);
    if (a < 32)  return 0;
    if (a < 160) return 1;
    if (a < 192) return 2;
    if (a < 224) return 3;
    if (a < 232) return 4;
    if (a < 240) return 5;
    return 6;
  endfunction

  function automatic int wp_ok(input int r);
    return (m_mem[225] >> r) & 1;
  endfunction

  function automatic int ext_rd_ok(input int a);
    int r = rgn(a);
    if (r <= 2) return m_mem[224] & 1;
    if (r == 3) return (m_mem[224] >> 1) & 1;
    return 1;
  endfunction

  function automatic int wr_ok(input int a);
    int r = rgn(a);
    if (r <= 4) return wp_ok(r);
    return (r == 5) ? 1 : 0;
  endfunction

  function automatic void model_reset();
    for (int a = 0; a < 256; a++) m_mem[a] = (a >= 240) ? ((a * 37 + 11) & 255) : 255;
    m_left = 0; m_err = 0; x_erv = 0; x_irv = 0; x_erd = 0; x_ird = 0;
  endfunction

  function automatic void model_step();
    int set_err = 0;
    x_erv = 0; x_irv = 0;
    if (m_left > 0) begin
      m_left--;
    end else if (ext_erase) begin
      for (int a = 0; a < 240; a++) m_mem[a] = 255;
      m_left = 242;
    end else if (ext_valid) begin
      if (ext_we) begin
        if (ext_rd_ok(ext_addr) != 0 && wr_ok(ext_addr) != 0) m_mem[ext_addr] = ext_wdata;
      end else begin
        x_erv = 1;
        x_erd = (ext_rd_ok(ext_addr) != 0) ? m_mem[ext_addr] : 0;
      end
    end else if (int_valid) begin
      if (int_we) begin
        if (wr_ok(int_addr) != 0) m_mem[int_addr] = int_wdata;
        else if (rgn(int_addr) <= 4) set_err = 1;
      end else begin
        x_irv = 1;
        x_ird = m_mem[int_addr];
      end
    end
    if (set_err != 0)    m_err = 1;
    else if (int_err_clr) m_err = 0;
  endfunction

  task automatic chk(input string what, input integer act, input integer exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #5;
    if (rst_n && !done) begin
      chk("busy", busy, (m_left > 0) ? 1 : 0);
      chk("wr_err", wr_err, m_err);
      chk("ext_ready", ext_ready, (m_left == 0 && !ext_erase) ? 1 : 0);
      chk("int_ready", int_ready, (m_left == 0 && !ext_erase && !ext_valid) ? 1 : 0);
      chk("ext_rvalid", ext_rvalid, x_erv);
      chk("int_rvalid", int_rvalid, x_irv);
      if (x_erv != 0) chk("ext_rdata", ext_rdata, x_erd);
      if (x_irv != 0) chk("int_rdata", int_rdata, x_ird);
    end
  end

  task automatic ext_op(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ext_valid = 1'b1; ext_we = we; ext_addr = a; ext_wdata = d;
    @(negedge clk); ext_valid = 1'b0; ext_we = 1'b0;
  endtask

  task automatic int_op(input logic we, input logic [7:0] a, input logic [7:0] d, input logic clr);
    @(negedge clk); int_valid = 1'b1; int_we = we; int_addr = a; int_wdata = d; int_err_clr = clr;
    @(negedge clk); int_valid = 1'b0; int_we = 1'b0; int_err_clr = 1'b0;
  endtask

  task automatic err_clear();
    @(negedge clk); int_err_clr = 1'b1;
    @(negedge clk); int_err_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1";  // reset content and region map
    int_op(0, 8'h00, 0, 0); int_op(0, 8'hF0, 0, 0); int_op(0, 8'hFF, 0, 0);
    ext_op(0, 8'hF5, 0); ext_op(0, 8'hE8, 0); ext_op(0, 8'hBF, 0);

    cur_req = "R3";  // one-cycle read latency, back-to-back
    ext_op(1, 8'h30, 8'h12); ext_op(0, 8'h30, 0);
    int_op(1, 8'hC5, 8'h77, 0); int_op(0, 8'hC5, 0, 0);

    cur_req = "R2";  // both ports in one cycle; internal held
    @(negedge clk);
    ext_valid = 1; ext_we = 1; ext_addr = 8'h40; ext_wdata = 8'hA5;
    int_valid = 1; int_we = 1; int_addr = 8'h41; int_wdata = 8'h5A;
    @(negedge clk); ext_valid = 0; ext_we = 0;
    @(negedge clk); int_valid = 0; int_we = 0;
    ext_op(0, 8'h40, 0); int_op(0, 8'h41, 0, 0);

    cur_req = "R7";  // data EEPROM write-protect
    ext_op(1, 8'hE1, 8'hF7);
    ext_op(1, 8'hC6, 8'h11); int_op(0, 8'hC6, 0, 0);
    cur_req = "R8";
    int_op(1, 8'hC6, 8'h22, 0); idle(2); int_op(0, 8'hC6, 0, 0);
    err_clear(); idle(1);
    ext_op(1, 8'hC7, 8'h33); idle(1);

    cur_req = "R4";  // program code-protect
    ext_op(1, 8'hE0, 8'hFE);
    ext_op(0, 8'h30, 0); ext_op(0, 8'h05, 0); ext_op(0, 8'hA8, 0);
    ext_op(1, 8'h31, 8'h99); int_op(0, 8'h31, 0, 0);
    cur_req = "R6";
    int_op(0, 8'h30, 0, 0); int_op(1, 8'h32, 8'h55, 0); int_op(0, 8'h32, 0, 0);

    cur_req = "R5";  // data code-protect, separate from program
    ext_op(0, 8'hC5, 0);
    ext_op(1, 8'hE0, 8'hFC);
    ext_op(0, 8'hC5, 0); int_op(0, 8'hC5, 0, 0); ext_op(1, 8'hC8, 8'h44);
    int_op(0, 8'hC8, 0, 0);

    cur_req = "R7";  // application and configuration write-protect
    ext_op(1, 8'hE1, 8'hE5);
    int_op(1, 8'h33, 8'h66, 0); int_op(0, 8'h33, 0, 0);
    ext_op(1, 8'hE0, 8'hFF); ext_op(0, 8'hE0, 0);
    int_op(1, 8'hE1, 8'hFF, 0); int_op(0, 8'hE1, 0, 0);

    cur_req = "R8";  // set wins over clear
    err_clear(); idle(1);
    int_op(1, 8'h34, 8'h01, 1); idle(2);
    err_clear(); idle(1);

    cur_req = "R9";  // user ID open, factory read-only
    ext_op(1, 8'hEA, 8'h3C); ext_op(0, 8'hEA, 0);
    int_op(1, 8'hEB, 8'hC3, 0); ext_op(0, 8'hEB, 0);
    ext_op(1, 8'hF2, 8'h00); int_op(1, 8'hF3, 8'h00, 0);
    int_op(0, 8'hF2, 0, 0); ext_op(0, 8'hF3, 0);

    cur_req = "R10";  // bulk erase, requests refused meanwhile
    int_op(1, 8'h35, 8'h02, 0);
    @(negedge clk); ext_erase = 1; ext_valid = 1; ext_we = 0; ext_addr = 8'h30;
    @(negedge clk); ext_erase = 0; ext_valid = 0;
    idle(50);
    ext_op(0, 8'h30, 0); int_op(1, 8'h36, 8'h00, 0);
    idle(200);
    ext_op(0, 8'h30, 0); ext_op(0, 8'hE0, 0); ext_op(0, 8'hE1, 0);
    ext_op(0, 8'hC5, 0); ext_op(0, 8'hEA, 0); ext_op(0, 8'hF2, 0);
    int_op(1, 8'h36, 8'h77, 0); ext_op(0, 8'h36, 0);
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule